// File: doc/BRIEF.md
# Binary k-of-n Combination Generator

This block walks through every N-bit word that has exactly K bits set, one word per clock, from the numerically largest to the smallest. The order is reverse lexicographic. Position 1 of the pattern is the most significant bit of the output, so the run begins with the K upper bits set and ends with the K lower bits set. N and K are fixed when the block is elaborated.

A one-cycle start pulse, given while the block is idle, loads the first word and raises the busy flag. Each later clock produces the next word. A table of K small counters, a step register and an index register hold the position in the walk, and combinational logic forms the whole next word, so every update lands on a single clock edge. After the last word the busy flag drops and the output returns to zero. The block then waits for the next start pulse. Typical uses are sweeping masks or comparand vectors of fixed Hamming weight.

Top module: `combgen`

## Requirements
- R1: An active-low reset, asserted at any time and without waiting for a clock, forces `busy_o` low and `vec_o` to all zeros.
- R2: A high `start_i` sampled on a rising edge while idle makes `busy_o` high after that edge, with `vec_o` holding the K most significant bits set and the rest clear (for N=6, K=3: 6'b111000).
- R3: Every word presented while `busy_o` is high has exactly K ones.
- R4: Each word after the first is the next smaller N-bit value with exactly K ones, where bit N-1 is pattern position 1.
- R5: `busy_o` stays high for exactly C(N,K) consecutive cycles per run. Afterwards `busy_o` is low and `vec_o` is zero for as long as the block stays idle.
- R6: The last word of a run has the K least significant bits set.
- R7: `start_i` has no effect while `busy_o` is high, including on the cycle that shows the last word.
- R8: A start after a completed run, or after a reset that cut a run short, repeats the whole walk from the first word.
- R9: Extreme parameters work. With K=N the run is the single all-ones word. With K=1 a single one moves from the MSB down to the LSB over N cycles.
- R10: For N=6 and K=3 the words in hex are 38, 34, 32, 31, 2c, 2a, 29, 26, 25, 23, 1c, 1a, 19, 16, 15, 13, 0e, 0d, 0b, 07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a run when sampled high while idle |
| vec_o | output | N | Current K-weight word; zero when idle |
| busy_o | output | 1 | High while words are being produced |

## Verification
The hardest situations to reach are a start pulse on the very cycle that shows the last word, and a reset arriving part-way through a walk. Both sit at one exact cycle of a run that lasts C(N,K) cycles. The bench counts the words it has checked. It places an extra start pulse at a cycle drawn at random inside the run, sometimes forced onto the final word, and drops the reset at a random depth in the walk before restarting. Several generators with different (N,K) run side by side, including K=N and K=1. The expected words come from a brute-force search for the next smaller value of weight K.

// File: rtl/combgen_pkg.sv
package combgen_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // bits needed to hold any value 0..maxval
    function automatic int span_width(int maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/combgen_pattern.sv
module combgen_pattern
    import combgen_pkg::*;
#(
    parameter int N  = 6,
    parameter int K  = 3,
    parameter int SW = 3,
    parameter int IW = 2,
    parameter int VW = 4
) (
    input  logic [N-1:0]  pat_i,
    input  logic [IW-1:0] ind_i,
    input  logic [SW-1:0] s_i,
    input  logic          tail_i,
    output logic [N-1:0]  pat_o
);

    logic [VW-1:0] v_w;
    logic [VW-1:0] lim_w;

    always_comb begin
        v_w   = VW'(ind_i) + VW'(s_i);
        lim_w = VW'(K) + VW'(s_i);
    end

    // position p (1..N) lives at bit N-p
    for (genvar p = 1; p <= N; p++) begin : g_bit
        always_comb begin
            if (VW'(p) == v_w - VW'(1)) begin
                pat_o[N-p] = 1'b1;
            end else if (VW'(p) == v_w - VW'(2)) begin
                pat_o[N-p] = 1'b0;
            end else if (tail_i && (VW'(p) >= v_w)) begin
                pat_o[N-p] = (VW'(p) < lim_w);
            end else begin
                pat_o[N-p] = pat_i[N-p];
            end
        end
    end

endmodule

// File: rtl/combgen_table.sv
module combgen_table
    import combgen_pkg::*;
#(
    parameter int K  = 3,
    parameter int SW = 3,
    parameter int IW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          init_i,
    input  logic          step_i,
    input  logic [IW-1:0] ind_i,
    input  logic [SW-1:0] s_i,
    output logic [SW-1:0] prev_o
);

    logic [SW-1:0] ent_d [K];
    logic [SW-1:0] ent_q [K];

    for (genvar j = 0; j < K; j++) begin : g_ent
        always_comb begin
            if (init_i) begin
                ent_d[j] = SW'(1);
            end else if (step_i && (int'(ind_i) <= j + 1)) begin
                ent_d[j] = s_i;
            end else begin
                ent_d[j] = ent_q[j];
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ent_q[j] <= '0;
            end else begin
                ent_q[j] <= ent_d[j];
            end
        end

        if (j < K - 1) begin : g_order
            AST_TABLE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ent_q[j] <= ent_q[j+1]);  // R4
        end
    end

    // entry just before the current index (positions are 1-based)
    always_comb begin
        prev_o = '0;
        for (int j = 0; j < K; j++) begin
            if (int'(ind_i) == j + 2) begin
                prev_o = ent_q[j];
            end
        end
    end

endmodule

// File: rtl/combgen.sv
module combgen
    import combgen_pkg::*;
#(
    parameter int N = 6,
    parameter int K = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    output logic [N-1:0] vec_o,
    output logic         busy_o
);

    localparam int MAXV = N - K + 1;
    localparam int SW   = span_width(MAXV + 1);
    localparam int IW   = span_width(K);
    localparam int VW   = span_width(N + 2);
    localparam logic [N-1:0] FIRST_VEC = ~({N{1'b1}} >> K);
    localparam logic [N-1:0] LAST_VEC  = ~({N{1'b1}} << K);

    typedef struct packed {
        phase_e        phase;
        logic [N-1:0]  pat;
        logic [IW-1:0] ind;
        logic [SW-1:0] s;
    } state_t;

    state_t        st_d, st_q;
    logic [N-1:0]  pat_step_w;
    logic [SW-1:0] prev_w;
    logic          last_w, step_w, init_w, below_max_w, tail_w;

    always_comb begin
        last_w      = (st_q.ind == '0) || (K == N);
        below_max_w = (st_q.s < SW'(MAXV));
        tail_w      = below_max_w && (st_q.ind < IW'(K));
        init_w      = (st_q.phase == PH_IDLE) && start_i;
        step_w      = (st_q.phase == PH_RUN) && !last_w;
    end

    combgen_pattern #(.N(N), .K(K), .SW(SW), .IW(IW), .VW(VW)) pattern_i (
        .pat_i  (st_q.pat),
        .ind_i  (st_q.ind),
        .s_i    (st_q.s),
        .tail_i (tail_w),
        .pat_o  (pat_step_w)
    );

    combgen_table #(.K(K), .SW(SW), .IW(IW)) table_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .init_i (init_w),
        .step_i (step_w),
        .ind_i  (st_q.ind),
        .s_i    (st_q.s),
        .prev_o (prev_w)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.pat   = FIRST_VEC;
                    st_d.ind   = IW'(K);
                    st_d.s     = SW'(2);
                end
            end
            PH_RUN: begin
                if (last_w) begin
                    st_d.phase = PH_IDLE;
                    st_d.pat   = '0;
                end else begin
                    st_d.pat = pat_step_w;
                    if (below_max_w) begin
                        st_d.s = st_q.s + SW'(1);
                        if (st_q.ind < IW'(K)) begin
                            st_d.ind = IW'(K);
                        end
                    end else begin
                        st_d.s   = (st_q.ind > IW'(1)) ? prev_w + SW'(1)
                                                       : st_q.s + SW'(1);
                        st_d.ind = st_q.ind - IW'(1);
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.pat   <= '0;
            st_q.ind   <= '0;
            st_q.s     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o  = st_q.pat;
    assign busy_o = (st_q.phase == PH_RUN);

    AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> (busy_o && vec_o == FIRST_VEC));  // R2
    AST_WEIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> ($countones(vec_o) == K));  // R3
    AST_DESCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> (vec_o < $past(vec_o)));  // R4
    AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (vec_o == '0));  // R5
    AST_LAST_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && vec_o == LAST_VEC) |=> !busy_o);  // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (int'(st_q.s) <= MAXV + 1));  // R6
    AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && vec_o != LAST_VEC) |=> (busy_o && vec_o != FIRST_VEC));  // R7
    AST_FLIP_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_w |-> (int'(st_q.ind) + int'(st_q.s) <= N + 1));  // R3

endmodule

// File: tb/combgen_tb_top.sv
module combgen_tb_top;

    localparam int NDUT = 4;
    localparam int NN [NDUT] = '{6, 5, 7, 8};
    localparam int KK [NDUT] = '{3, 5, 1, 4};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst_n;
    logic [NDUT-1:0]       start_r;
    logic [NDUT-1:0][7:0]  vec_w;
    logic [NDUT-1:0]       busy_w;

    int n_tests = 0;
    int n_fail  = 0;

    for (genvar g = 0; g < NDUT; g++) begin : g_dut
        logic [NN[g]-1:0] v;
        combgen #(.N(NN[g]), .K(KK[g])) dut_i (
            .clk_i   (clk),
            .rst_ni  (rst_n),
            .start_i (start_r[g]),
            .vec_o   (v),
            .busy_o  (busy_w[g])
        );
        assign vec_w[g] = 8'(v);
    end

    function automatic int popc(logic [7:0] x);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(x[i]);
        return c;
    endfunction

    function automatic int binom(int n, int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    function automatic logic [7:0] first_vec(int n, int k);
        return 8'(((1 << k) - 1) << (n - k));
    endfunction

    function automatic logic [7:0] next_vec(logic [7:0] cur, int k);
        for (int x = int'(cur) - 1; x >= 0; x--) begin
            if (popc(8'(x)) == k) return 8'(x);
        end
        return 8'h00;
    endfunction

    task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // one full run on generator g; inj < 0 means no extra start pulse
    task automatic run_one(int g, int inj);
        int n = NN[g];
        int k = KK[g];
        int cnt = binom(n, k);
        logic [7:0] exp = first_vec(n, k);
        string seq_tag = (g == 0) ? "R10" : ((g == 3) ? "R4" : "R9");
        @(negedge clk);
        start_r[g] = 1'b1;
        @(negedge clk);
        start_r[g] = 1'b0;
        chk(vec_w[g] == exp, "R2 first word", vec_w[g], exp);
        for (int i = 0; i < cnt; i++) begin
            start_r[g] = 1'b0;
            chk(busy_w[g] == 1'b1, "R5 busy during run", 8'(busy_w[g]), 8'h01);
            chk(vec_w[g] == exp, seq_tag, vec_w[g], exp);
            chk(popc(vec_w[g]) == k, "R3 weight", 8'(popc(vec_w[g])), 8'(k));
            if (i == cnt - 1)
                chk(vec_w[g] == 8'((1 << k) - 1), "R6 last word", vec_w[g], 8'((1 << k) - 1));
            if (i == inj) start_r[g] = 1'b1;
            exp = next_vec(exp, k);
            @(negedge clk);
        end
        start_r[g] = 1'b0;
        chk(busy_w[g] == 1'b0, "R5 busy after run", 8'(busy_w[g]), 8'h00);
        chk(vec_w[g] == 8'h00, "R5 zero after run", vec_w[g], 8'h00);
        @(negedge clk);
        chk(busy_w[g] == 1'b0, "R7 idle stays idle", 8'(busy_w[g]), 8'h00);
        chk(vec_w[g] == 8'h00, "R7 idle output zero", vec_w[g], 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R5 watchdog expired");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        start_r = '0;
        rst_n   = 1'b0;
        #1;
        for (int g = 0; g < NDUT; g++) begin
            chk(busy_w[g] == 1'b0, "R1 reset busy", 8'(busy_w[g]), 8'h00);
            chk(vec_w[g] == 8'h00, "R1 reset vec", vec_w[g], 8'h00);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // directed: every generator once, plain
        for (int g = 0; g < NDUT; g++) run_one(g, -1);
        // directed: start pulse on the final word, then restart
        run_one(0, binom(6, 3) - 1);
        run_one(0, -1);  // R8 restart repeats the walk
        run_one(3, binom(8, 4) - 1);

        // random: generator, idle gap and extra start position
        for (int r = 0; r < 12; r++) begin
            int g = int'($urandom_range(NDUT - 1, 0));
            int cnt = binom(NN[g], KK[g]);
            int inj = int'($urandom_range(cnt - 1, 0));
            repeat (int'($urandom_range(3, 0))) @(negedge clk);
            run_one(g, ($urandom_range(1, 0) == 1) ? inj : -1);
        end

        // random: reset part-way through a walk, then a full restart
        for (int r = 0; r < 4; r++) begin
            int g = (r % 2 == 0) ? 0 : 3;
            int depth = int'($urandom_range(binom(NN[g], KK[g]) - 2, 1));
            @(negedge clk);
            start_r[g] = 1'b1;
            @(negedge clk);
            start_r[g] = 1'b0;
            repeat (depth) @(negedge clk);
            #1 rst_n = 1'b0;
            #0.5;
            chk(busy_w[g] == 1'b0, "R1 async reset busy", 8'(busy_w[g]), 8'h00);
            chk(vec_w[g] == 8'h00, "R1 async reset vec", vec_w[g], 8'h00);
            @(negedge clk);
            rst_n = 1'b1;
            run_one(g, -1);  // R8 after an aborted run
        end

        report();
    end

endmodule